// File: doc/BRIEF.md
# SAR converter serial readout controller

This block sits on the host side of a three-wire serial link to a 14-bit differential successive-approximation converter. A single-cycle start request makes it pull chip select low, which also makes the converter sample its input. The block then drives a burst of serial clocks taken from a divided system clock and collects the converter's output bits. It returns the conversion as a parallel two's-complement word, together with a one-cycle valid strobe. The serial clock also runs the conversion, so every frame keeps a steady clock from the first edge to the last. The word always belongs to the conversion that the same chip-select assertion started.

A normal frame has eighteen serial clocks. The caller can ask for fewer result bits. In that case the block ends the frame once the last requested bit is in, and it returns those bits at the top of the word with zeros below them. Chip select is always held high for a minimum spacing between frames. A start request that arrives before the block is idle again is dropped.

Top module: `sar_rd_ctrl`

## Requirements
- R1: After reset, cs_n_o and sclk_o are 1, valid_o and busy_o are 0, and result_o is zero.
- R2: cs_n_o goes low only in the cycle after a start_i pulse seen while busy_o is 0, and busy_o stays high for as long as cs_n_o is low.
- R3: With nbits_i equal to 14, a frame has exactly 18 falling edges of sclk_o while cs_n_o is low.
- R4: Each sclk_o half period lasts max(div_i, 4) system clocks. The value is taken from div_i when start_i is accepted, so later changes to div_i do not affect the running frame. Whenever cs_n_o is high, sclk_o is high.
- R5: Counting rising edges of sclk_o from the fall of cs_n_o, edge 3 carries result bit 13 (the MSB). Each later edge carries the next lower bit, so edge 16 carries bit 0.
- R6: When nbits_i is n with 1 <= n <= 13, the frame ends after rising edge 2+n, giving 2+n falling edges. result_o then holds the n captured bits in bits 13 down to 14-n, and zeros in the bits below.
- R7: An nbits_i value of 0, or of 15 or more, gives a full 14-bit, 18-clock frame.
- R8: valid_o is high for exactly one cycle. That is the cycle in which cs_n_o returns high, one half period after the last rising edge. result_o takes the new word in that same cycle and keeps it until the next valid_o.
- R9: A start_i pulse seen while busy_o is 1 does not start a frame and does not produce a valid_o.
- R10: Between the rise of cs_n_o and its next fall, cs_n_o stays high for at least 4 half periods, which is two serial clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to run a conversion |
| div_i | input | 8 | Serial clock half period in system clocks (values below 4 act as 4) |
| nbits_i | input | 4 | Requested result bits (0 or above 14 means 14) |
| sdo_i | input | 1 | Serial data from the converter, synchronized internally |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| busy_o | output | 1 | High from the accepted start until the inter-frame spacing ends |
| valid_o | output | 1 | One-cycle strobe for a new result |
| result_o | output | 14 | Two's-complement result, left-justified for short reads |

## Verification
The converter model drives ones on every bit slot outside the data window. Because of this, a capture that starts one edge early or late changes the returned word, and a short read that fails to clear its unread low bits shows up as ones where zeros are expected. The bench counts falling edges and measures the last low phase of each frame. A divider that misses the minimum clamp, or that reloads from div_i in the middle of a frame, produces a wrong half period. A short-cycle limit that is off by one produces a wrong edge count. The bench also sends start requests in the middle of a frame and during the spacing interval, and measures how long chip select stays high between back-to-back frames. A controller that accepts those requests, or that reopens chip select too soon, gives an extra result or a gap that is too short.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_LOW  = 3'd2,
    ST_HIGH = 3'd3,
    ST_END  = 3'd4,
    ST_GAP  = 3'd5
  } rd_state_e;

endpackage

// File: rtl/sar_rd_sync.sv
module sar_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= 1'b0;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sar_rd_div.sv
module sar_rd_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == half_i - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i & at_end;

endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
  parameter int DATA_W = 14,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic bit_q;
      logic bit_d;
      logic hit;

      assign hit = we_i && (pos_i == POS_W'(i));

      always_comb begin
        bit_d = bit_q;
        if (clr_i)    bit_d = 1'b0;
        else if (hit) bit_d = bit_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end

      assign word_o[i] = bit_q;
    end
  endgenerate

endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int FRAME_CLKS  = 18,
  parameter int LEAD_RISES  = 2,
  parameter int DIV_W       = 8,
  parameter int MIN_HALF    = 4,
  parameter int GAP_PERIODS = 2,
  parameter int SYNC_STAGES = 2,
  parameter int NB_W        = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int RC_W = $clog2(FRAME_CLKS + 1);
  localparam int POS_W = $clog2(DATA_W);
  localparam int GAP_TICKS = 2 * GAP_PERIODS;
  localparam int GC_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

  localparam logic [NB_W-1:0]  NB_FULL    = NB_W'(DATA_W);
  localparam logic [RC_W-1:0]  RISE_FULL  = RC_W'(FRAME_CLKS);
  localparam logic [RC_W-1:0]  RISE_LEAD  = RC_W'(LEAD_RISES);
  localparam logic [RC_W-1:0]  RISE_TOP   = RC_W'(LEAD_RISES + DATA_W);
  localparam logic [DIV_W-1:0] HALF_MIN   = DIV_W'(MIN_HALF);
  localparam logic [GC_W-1:0]  GAP_LAST   = GC_W'(GAP_TICKS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_core_n = rst_pipe_q[1];

  // state and datapath registers
  rd_state_e         state_q, state_d;
  logic              cs_n_q, cs_n_d;
  logic              sclk_q, sclk_d;
  logic              valid_q, valid_d;
  logic [RC_W-1:0]   rise_q, rise_d;
  logic [NB_W-1:0]   nb_q, nb_d;
  logic [DIV_W-1:0]  half_q, half_d;
  logic [GC_W-1:0]   gap_q, gap_d;
  logic [DATA_W-1:0] res_q, res_d;

  // helper nets
  logic              tick;
  logic              run;
  logic              sdo_sync;
  logic              cap_clr;
  logic              cap_en;
  logic [POS_W-1:0]  cap_pos;
  logic [DATA_W-1:0] cap_word;
  logic [NB_W-1:0]   nb_req;
  logic [DIV_W-1:0]  half_req;
  logic [RC_W-1:0]   rise_nx;
  logic [RC_W-1:0]   last_rise;
  logic              in_window;

  assign run       = (state_q != ST_IDLE);
  assign nb_req    = ((nbits_i == '0) || (nbits_i > NB_FULL)) ? NB_FULL : nbits_i;
  assign half_req  = (div_i < HALF_MIN) ? HALF_MIN : div_i;
  assign rise_nx   = rise_q + RC_W'(1);
  assign last_rise = (nb_q == NB_FULL) ? RISE_FULL : (RISE_LEAD + RC_W'(nb_q));
  assign in_window = (rise_nx > RISE_LEAD) && (rise_nx <= (RISE_LEAD + RC_W'(nb_q)));
  assign cap_pos   = POS_W'(RISE_TOP - rise_nx);

  sar_rd_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (sdo_i),
    .q_o   (sdo_sync)
  );

  sar_rd_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run_i  (run),
    .half_i (half_q),
    .tick_o (tick)
  );

  sar_rd_capture #(
    .DATA_W (DATA_W),
    .POS_W  (POS_W)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_i  (cap_clr),
    .we_i   (cap_en),
    .pos_i  (cap_pos),
    .bit_i  (sdo_sync),
    .word_o (cap_word)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    valid_d = 1'b0;
    rise_d  = rise_q;
    nb_d    = nb_q;
    half_d  = half_q;
    gap_d   = gap_q;
    res_d   = res_q;
    cap_clr = 1'b0;
    cap_en  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LEAD;
          cs_n_d  = 1'b0;
          nb_d    = nb_req;
          half_d  = half_req;
          rise_d  = '0;
          cap_clr = 1'b1;
        end
      end
      ST_LEAD, ST_HIGH: begin
        if (tick) begin
          sclk_d  = 1'b0;
          state_d = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tick) begin
          sclk_d  = 1'b1;
          rise_d  = rise_nx;
          cap_en  = in_window;
          state_d = (rise_nx == last_rise) ? ST_END : ST_HIGH;
        end
      end
      ST_END: begin
        if (tick) begin
          cs_n_d  = 1'b1;
          valid_d = 1'b1;
          res_d   = cap_word;
          gap_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_q == GAP_LAST) state_d = ST_IDLE;
          else                   gap_d   = gap_q + GC_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      valid_q <= 1'b0;
      rise_q  <= '0;
      nb_q    <= NB_FULL;
      half_q  <= HALF_MIN;
      gap_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      valid_q <= valid_d;
      rise_q  <= rise_d;
      nb_q    <= nb_d;
      half_q  <= half_d;
      gap_q   <= gap_d;
      res_q   <= res_d;
    end
  end

  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
  assign busy_o   = run;
  assign valid_o  = valid_q;
  assign result_o = res_q;

endmodule

// File: rtl/sar_rd_chk.sv
module sar_rd_chk #(
  parameter int DATA_W      = 14,
  parameter int FRAME_CLKS  = 18,
  parameter int MIN_HALF    = 4,
  parameter int GAP_PERIODS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);

  localparam int GAP_MIN = 2 * GAP_PERIODS * MIN_HALF;
  localparam int HC_W = $clog2(GAP_MIN + 1);
  localparam int FC_W = $clog2(FRAME_CLKS + 2);

  logic [HC_W-1:0] hi_cnt;
  logic [FC_W-1:0] fall_cnt;
  logic            sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= HC_W'(GAP_MIN);
      fall_cnt  <= '0;
      sclk_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_o;
      if (cs_n_o) begin
        fall_cnt <= '0;
        if (hi_cnt != HC_W'(GAP_MIN)) hi_cnt <= hi_cnt + HC_W'(1);
      end else begin
        hi_cnt <= '0;
        if (sclk_prev && !sclk_o && (fall_cnt != {FC_W{1'b1}}))
          fall_cnt <= fall_cnt + FC_W'(1);
      end
    end
  end

  assert_cs_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));

  assert_busy_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (fall_cnt <= FC_W'(FRAME_CLKS)));

  assert_sclk_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  assert_valid_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_valid_at_cs_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !$fell(cs_n_o));

  assert_gap_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt >= HC_W'(GAP_MIN)));

endmodule

bind sar_rd_ctrl sar_rd_chk #(
  .DATA_W      (DATA_W),
  .FRAME_CLKS  (FRAME_CLKS),
  .MIN_HALF    (MIN_HALF),
  .GAP_PERIODS (GAP_PERIODS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .cs_n_o   (cs_n_o),
  .sclk_o   (sclk_o),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/sar_rd_ctrl_tb.sv
`timescale 1ns/1ps
module sar_rd_ctrl_tb;

  localparam int DW    = 14;
  localparam int FRAME = 18;
  localparam int LEAD  = 2;

  typedef struct {
    logic [DW-1:0] res;
    int            falls;
    int            half;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [7:0]    div_i;
  logic [3:0]    nbits_i;
  logic          sdo;
  logic          cs_n_o;
  logic          sclk_o;
  logic          busy_o;
  logic          valid_o;
  logic [DW-1:0] result_o;

  int            total;
  int            bad;
  bit            finished;
  exp_t          q[$];
  exp_t          e;
  logic [DW-1:0] cur_word;

  // monitor state
  logic prev_cs, prev_sclk, prev_valid;
  int   falls, lowrun, lasthalf, hicnt, gap_need;
  bit   idle_low_seen;

  sar_rd_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .div_i    (div_i),
    .nbits_i  (nbits_i),
    .sdo_i    (sdo),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic model_bit(input int k);
    if (k >= LEAD + 1 && k <= LEAD + DW) return cur_word[LEAD + DW - k];
    return 1'b1;
  endfunction

  // converter model: new bit after each falling serial clock edge
  initial begin
    sdo = 1'b1;
    forever begin
      @(negedge cs_n_o);
      begin
        int k;
        k = 0;
        sdo = 1'b1;
        while (!cs_n_o) begin
          @(negedge sclk_o or posedge cs_n_o);
          if (!cs_n_o) begin
            k++;
            #1 sdo = model_bit(k);
          end
        end
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b1; prev_valid = 1'b0;
      falls = 0; lowrun = 0; lasthalf = 0; hicnt = 0; gap_need = 0;
    end else begin
      if (cs_n_o && !sclk_o) idle_low_seen = 1'b1;
      if (valid_o) begin
        if (prev_valid) chk(1'b0, "R8 valid wider than one cycle", 1, 0);
        chk(!prev_cs && cs_n_o, "R8 valid with chip select rise", longint'(cs_n_o), 1);
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected result", longint'(result_o), 0);
        end else begin
          e = q.pop_front();
          chk(result_o == e.res, (e.falls < FRAME) ? "R6 short result" : "R5 result",
              longint'(result_o), longint'(e.res));
          chk(falls == e.falls, (e.falls < FRAME) ? "R6 clock count" : "R3 clock count",
              falls, e.falls);
          chk(lasthalf == e.half, "R4 half period", lasthalf, e.half);
          gap_need = 4 * e.half;
        end
      end
      if (prev_cs && !cs_n_o) begin
        if (gap_need > 0) chk(hicnt >= gap_need, "R10 chip select gap", hicnt, gap_need);
        falls = 0;
        lowrun = 0;
      end
      if (!cs_n_o) begin
        hicnt = 0;
        if (prev_sclk && !sclk_o) falls++;
        if (!sclk_o) lowrun++;
        else if (lowrun > 0) begin
          lasthalf = lowrun;
          lowrun = 0;
        end
      end else begin
        hicnt++;
      end
      prev_cs = cs_n_o;
      prev_sclk = sclk_o;
      prev_valid = valid_o;
    end
  end

  // driver: poke 1 = start mid-frame, poke 2 = start during spacing
  task automatic run_frame(input int div, input int nb, input logic [DW-1:0] word,
                           input int poke, input int new_div);
    exp_t x;
    int ne;
    logic [DW-1:0] m;
    ne = (nb == 0 || nb > DW) ? DW : nb;
    m = {DW{1'b1}} << (DW - ne);
    x.res = word & m;
    x.falls = (ne == DW) ? FRAME : LEAD + ne;
    x.half = (div < 4) ? 4 : div;
    q.push_back(x);
    cur_word = word;
    @(negedge clk);
    div_i = 8'(div);
    nbits_i = 4'(nb);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke == 1) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (new_div > 0) begin
      repeat (12) @(negedge clk);
      div_i = 8'(new_div);
    end
    while (q.size() != 0) @(negedge clk);
    if (poke == 2) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(result_o == x.res, "R8 result held", longint'(result_o), longint'(x.res));
    while (busy_o) @(negedge clk);
    if (poke != 0) begin
      repeat (12) @(negedge clk);
      chk(cs_n_o && !busy_o, "R9 busy start ignored", longint'({cs_n_o, busy_o}), 2);
    end
  endtask

  initial begin
    finished = 1'b0;
    idle_low_seen = 1'b0;
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    div_i = 8'd4;
    nbits_i = 4'd0;
    cur_word = '0;
    repeat (5) @(negedge clk);
    chk(cs_n_o && sclk_o, "R1 link idle in reset", longint'({cs_n_o, sclk_o}), 3);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!valid_o && !busy_o, "R1 no strobe after reset", longint'({valid_o, busy_o}), 0);
    chk(result_o == '0, "R1 result cleared", longint'(result_o), 0);
    begin
      bit held;
      held = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!cs_n_o) held = 1'b0;
      end
      chk(held, "R2 no chip select without start", longint'(held), 1);
    end

    run_frame(4, 14, 14'h1FFF, 0, 0);   // R5 most positive
    run_frame(4, 14, 14'h2000, 0, 0);   // R5 most negative
    run_frame(2, 14, 14'h2AAA, 0, 0);   // R4 clamp to minimum
    run_frame(7, 14, 14'h1555, 0, 0);   // R4 odd divider
    run_frame(5, 0, 14'h3C5A, 0, 0);    // R7 zero means full
    run_frame(4, 15, 14'h0F0F, 0, 0);   // R7 over-range means full
    run_frame(4, 1, 14'h3FFF, 0, 0);    // R6 single bit
    run_frame(6, 5, 14'h2B6D, 0, 0);    // R6 five bits
    run_frame(4, 13, 14'h3FFF, 0, 0);   // R6 thirteen bits
    run_frame(4, 14, 14'h1234, 1, 0);   // R9 start mid-frame
    run_frame(5, 14, 14'h0ABC, 0, 9);   // R4 divider change mid-frame
    run_frame(4, 8, 14'h3333, 2, 0);    // R10 start during spacing
    run_frame(4, 14, 14'h0001, 0, 0);   // R5 LSB only

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R9 all results delivered", q.size(), 0);
    chk(!idle_low_seen, "R4 serial clock high while deselected", longint'(idle_low_seen), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule